// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Controller

This block models the control logic of a byte-wide memory whose bits start erased and can only be cleared. Two active-low strobes, chip enable and output enable, are decoded together with a program-supply flag and an identification flag. The decode selects one of seven modes: read, output disable, standby, program, program verify, program inhibit and identification. The bidirectional data pins are split into a data-in byte, a data-out byte and an output-enable flag. A pad ring or bus model can merge them into a tri-state pin.

The stored array is small and sized by a parameter. It is addressed by the low bits of the address bus. Reset returns every bit to 1. While the program condition holds, each clock edge ANDs the data-in byte into the addressed location. Identification mode returns two fixed bytes, each with odd parity. It lets programming equipment recognise the part without touching the array.

Top module: `eprom_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises, every stored byte reads FFh until it is programmed.
- R2: With ce_ni=0, oe_ni=0, vpp_hi_i=0 and id_hv_i=0, data_oe_o is 1 and data_o is the byte stored at addr_i[ARR_AW-1:0]. Address bits above ARR_AW-1 do not select storage.
- R3: With ce_ni=0 and oe_ni=1, data_oe_o is 0 and data_o is 00h.
- R4: With ce_ni=1 (standby), data_oe_o is 0 and data_o is 00h whatever oe_ni is. No clock edge changes storage in this state, even with vpp_hi_i=1.
- R5: With vpp_hi_i=1, ce_ni=0 and oe_ni=1, each rising clock edge replaces the addressed byte with its bitwise AND with data_i. A bit once 0 stays 0 until reset.
- R6: With vpp_hi_i=1, ce_ni=0 and oe_ni=0 (program verify), data_oe_o is 1 and data_o is the stored byte. Storage is not written.
- R7: With vpp_hi_i=1, ce_ni=1 and oe_ni=1 (program inhibit), data_oe_o is 0 and storage is not written.
- R8: With id_hv_i=1, vpp_hi_i=0, ce_ni=0 and oe_ni=0, and every address bit except bits 0 and 9 at 0, data_oe_o is 1. data_o is 01h when addr_i[0]=0 and 10h when addr_i[0]=1. Both bytes have odd parity over all 8 bits, with bit 7 as the parity bit.
- R9: Under the conditions of R8, if any address bit other than bits 0 and 9 is 1, data_o is 00h with data_oe_o=1.
- R10: When vpp_hi_i=1, id_hv_i has no effect: ce_ni=0 and oe_ni=0 give the stored byte (R6), not an identification byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; programming acts on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset, erases the array to all ones |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (15) | Byte address |
| vpp_hi_i | input | 1 | Program supply is at programming level |
| id_hv_i | input | 1 | Address line 9 is held at the identification level |
| data_i | input | DATA_W (8) | Byte to program |
| data_o | output | DATA_W (8) | Byte driven toward the pins, 00h when not driven |
| data_oe_o | output | 1 | Data pins are driven when 1, high impedance when 0 |

## Verification
The bench programs one location several times with different bytes. A design that wrote the byte outright, instead of ANDing it, would make a cleared bit come back after a later program with FFh. Standby and inhibit are entered with the program supply raised and zeros on data_i. A decoder that let a write slip through in those states would change the byte read back afterwards. Identification is driven with address bit 9 set, with a stray low bit set, and with the program supply raised. A decoder that masked the wrong bits would return the wrong code, or 00h, in those cases. A decoder that gave identification priority over verify would show 01h where the stored FFh is expected. A read with a high address bit set catches an array that decodes too many address bits.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_OUT_DIS,
    MODE_READ,
    MODE_IDENT,
    MODE_PROG,
    MODE_VERIFY,
    MODE_INHIBIT
  } mode_e;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  vpp_hi_i,
  input  logic  id_hv_i,
  output mode_e mode_o
);
  always_comb begin
    if (ce_ni) begin
      mode_o = (vpp_hi_i && oe_ni) ? MODE_INHIBIT : MODE_STANDBY;
    end else if (vpp_hi_i) begin
      // program supply outranks identification
      mode_o = oe_ni ? MODE_PROG : MODE_VERIFY;
    end else if (oe_ni) begin
      mode_o = MODE_OUT_DIS;
    end else if (id_hv_i) begin
      mode_o = MODE_IDENT;
    end else begin
      mode_o = MODE_READ;
    end
  end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int DATA_W = 8,
  parameter int ARR_AW = 6,
  localparam int DEPTH = 1 << ARR_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ARR_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '1;
      end else if (wr_en_i && (addr_i == ARR_AW'(g))) begin
        mem_q[g] <= mem_q[g] & wr_data_i;  // only clears bits
      end
    end
  end

  assign rd_data_o = mem_q[addr_i];
endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux
  import eprom_pkg::*;
#(
  parameter int          ADDR_W   = 15,
  parameter int          DATA_W   = 8,
  parameter int          ID_LINE  = 9,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h01,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h10
) (
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam logic [ADDR_W-1:0] ID_MASK = ~((ADDR_W'(1) << ID_LINE) | ADDR_W'(1));

  logic id_addr_ok;
  assign id_addr_ok = ((addr_i & ID_MASK) == '0);

  always_comb begin
    data_o    = '0;
    data_oe_o = 1'b0;
    unique case (mode_i)
      MODE_READ, MODE_VERIFY: begin
        data_o    = rd_data_i;
        data_oe_o = 1'b1;
      end
      MODE_IDENT: begin
        data_oe_o = 1'b1;
        if (id_addr_ok) data_o = addr_i[0] ? DEV_CODE : MFR_CODE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int ARR_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vpp_hi_i,
  input  logic              id_hv_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  mode_e             mode;
  logic [DATA_W-1:0] rd_data;

  eprom_mode_dec u_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_hi_i (vpp_hi_i),
    .id_hv_i  (id_hv_i),
    .mode_o   (mode)
  );

  eprom_cell_array #(.DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (mode == MODE_PROG),
    .addr_i    (addr_i[ARR_AW-1:0]),
    .wr_data_i (data_i),
    .rd_data_o (rd_data)
  );

  eprom_out_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .mode_i    (mode),
    .addr_i    (addr_i),
    .rd_data_i (rd_data),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );
endmodule

// File: rtl/eprom_ctrl_chk.sv
module eprom_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              vpp_hi_i,
  input logic              id_hv_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  localparam logic [ADDR_W-1:0] OTHER = ~((ADDR_W'(1) << 9) | ADDR_W'(1));

  logic rd_now, rd_prev_q, id_now;
  assign rd_now = !ce_ni && !oe_ni && !vpp_hi_i && !id_hv_i;
  assign id_now = !ce_ni && !oe_ni && !vpp_hi_i && id_hv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_prev_q <= 1'b0;
    else         rd_prev_q <= rd_now;
  end

  assert_standby_hiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o && data_o == '0);

  assert_oe_high_hiz_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);

  assert_drive_needs_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !ce_ni && !oe_ni);

  assert_bits_never_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_now && rd_prev_q && $stable(addr_i)) |-> ((data_o & ~$past(data_o)) == '0));

  assert_id_odd_parity_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_now && (addr_i & OTHER) == '0) |-> data_oe_o && (^data_o));

  assert_id_bad_addr_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_now && (addr_i & OTHER) != '0) |-> data_oe_o && data_o == '0);
endmodule

bind eprom_ctrl eprom_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/eprom_ctrl_tb.sv
module eprom_ctrl_tb;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int ARR_AW = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, vpp_hi_i = 1'b0, id_hv_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              data_oe_o;

  int total = 0;
  int bad   = 0;

  always #2 clk_i = ~clk_i;

  eprom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_dut (.*);

  task automatic drive(input logic ce, oe, vpp, id, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    ce_ni = ce; oe_ni = oe; vpp_hi_i = vpp; id_hv_i = id; addr_i = a; data_i = d;
    #1;
  endtask

  task automatic chk(input string req, input logic exp_oe, input logic [DATA_W-1:0] exp_d);
    total++;
    if (data_oe_o !== exp_oe || data_o !== exp_d) begin
      bad++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", req, data_oe_o, data_o,
               exp_oe, exp_d);
    end
  endtask

  task automatic rd(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e);
    drive(0, 0, 0, 0, a, 8'h00);
    chk(req, 1'b1, e);
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    drive(0, 1, 1, 0, a, d);
    chk("R5 prog hiz", 1'b0, 8'h00);
    @(posedge clk_i);
  endtask

  task automatic t_reset;
    rd("R1 reset addr0", 15'd0, 8'hFF);
    rd("R1 reset addr63", 15'd63, 8'hFF);
  endtask

  task automatic t_program;
    prog(15'd3, 8'hA5);
    rd("R5 first prog", 15'd3, 8'hA5);
    prog(15'd3, 8'h0F);
    rd("R5 and second prog", 15'd3, 8'h05);
    prog(15'd3, 8'hFF);
    rd("R5 no bit restored", 15'd3, 8'h05);
    rd("R2 neighbour intact", 15'd4, 8'hFF);
    rd("R2 high addr bit ignored", 15'h0403, 8'h05);
  endtask

  task automatic t_disable;
    drive(0, 1, 0, 0, 15'd3, 8'h00);
    chk("R3 oe high", 1'b0, 8'h00);
    drive(1, 0, 0, 0, 15'd3, 8'h00);
    chk("R4 standby oe low", 1'b0, 8'h00);
    drive(1, 0, 1, 0, 15'd3, 8'h00);
    chk("R4 standby vpp", 1'b0, 8'h00);
    @(posedge clk_i);
    rd("R4 no write in standby", 15'd3, 8'h05);
  endtask

  task automatic t_verify_inhibit;
    drive(0, 0, 1, 0, 15'd3, 8'h00);
    chk("R6 verify drives", 1'b1, 8'h05);
    @(posedge clk_i);
    #1 chk("R6 verify no write", 1'b1, 8'h05);
    drive(1, 1, 1, 0, 15'd3, 8'h00);
    chk("R7 inhibit hiz", 1'b0, 8'h00);
    @(posedge clk_i);
    rd("R7 no write in inhibit", 15'd3, 8'h05);
  endtask

  task automatic t_ident;
    drive(0, 0, 0, 1, 15'd0, 8'h00);
    chk("R8 mfr code", 1'b1, 8'h01);
    drive(0, 0, 0, 1, 15'd1, 8'h00);
    chk("R8 dev code", 1'b1, 8'h10);
    drive(0, 0, 0, 1, 15'h0201, 8'h00);
    chk("R8 bit9 ignored", 1'b1, 8'h10);
    drive(0, 0, 0, 1, 15'd8, 8'h00);
    chk("R9 stray bit", 1'b1, 8'h00);
    drive(0, 0, 0, 1, 15'h4000, 8'h00);
    chk("R9 top bit", 1'b1, 8'h00);
    drive(0, 0, 1, 1, 15'd0, 8'h00);
    chk("R10 vpp wins over id", 1'b1, 8'hFF);
  endtask

  task automatic t_rereset;
    drive(1, 1, 0, 0, 15'd0, 8'h00);
    rst_ni = 1'b0;
    #3 rst_ni = 1'b1;
    rd("R1 erase after reset", 15'd3, 8'hFF);
  endtask

  initial begin
    #1 chk("R1 reset outputs", 1'b0, 8'h00);
    #6 rst_ni = 1'b1;
    t_reset();
    t_program();
    t_disable();
    t_verify_inhibit();
    t_ident();
    t_rereset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule